// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns a 28-bit parallel pixel word into four serial lanes and a framing clock, all timed by a bit clock that runs at seven times the pixel rate. The incoming pixel clock is brought into the bit-clock domain and watched for the edge polarity picked by a select input. Each such edge makes a single-cycle load strobe. The strobe captures the word, spreads it over four 7-slot slices through a fixed scrambled map, and restarts the slot counter. From then on, one bit per lane leaves on each bit-clock cycle.

A framing clock at the pixel rate goes out with the lanes. It is high for four slots and low for three, and it rises with slot 0. A lock flag tells the far end when the stream carries real data. An active-low run enable clears every register at once and keeps the lanes and framing clock quiet. The lanes, the framing clock and the lock flag are all registered, so they all change on the same bit-clock edge.

Top module: `px7_serializer`

## Requirements
- R1: Each lane sends its slots 0 to 6 in a fixed order of word bits. Lane 0 sends 1,0,7,6,4,3,2. Lane 1 sends 9,8,18,15,14,13,12. Lane 2 sends 20,19,26,25,24,22,21. Lane 3 sends 5,27,23,17,16,11,10.
- R2: Once locked, `clk_out` is high for the four bit cycles carrying slots 0 to 3 and low for slots 4 to 6. It rises in the same cycle that slot 0 appears.
- R3: With `rise_sel` = 1, a low-to-high change of `pix_clk` captures `pix_word`.
- R4: With `rise_sel` = 0, a high-to-low change of `pix_clk` captures `pix_word`, and a low-to-high change captures nothing.
- R5: While `run_en` is 0, `lane_out`, `clk_out` and `locked` are 0. The clear acts at once, without waiting for a clock edge.
- R6: After `run_en` rises, `lane_out` and `clk_out` stay 0 until the first word is captured. `locked` rises in the cycle that carries slot 0 of that word.
- R7: Suppose the new `pix_clk` level is first seen at bit-clock rising edge n. Then slot 0 of the captured word, with `clk_out` high, is driven from edge n+2. This is one load per pixel-clock edge.
- R8: If word bits 5, 10, 11, 16, 17, 23 and 27 are held at 0, lane 3 stays at 0 once such words are being sent.
- R9: If `pix_clk` stops, the last captured word repeats every seven bit cycles, and `clk_out` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| run_en | input | 1 | Active-low shutdown; 0 clears all state |
| pix_clk | input | 1 | Incoming pixel clock, asynchronous to `clk` |
| rise_sel | input | 1 | 1: capture on the rising pixel edge, 0: on the falling edge |
| pix_word | input | 28 | Parallel pixel word |
| lane_out | output | 4 | Serial data lanes |
| clk_out | output | 1 | Framing clock at the pixel rate |
| locked | output | 1 | High once the first word has been loaded |

## Verification
A pixel-clock edge is first seen at one bit-clock rising edge. The load strobe is raised after the second synchronizer stage, and slot 0 leaves on the edge two cycles after the first sample. So the bench's directed checks look for the framing clock low two falling edges after the stimulus and high on the third. A behavioural model keeps a queue of sampled pixel-clock levels and works out each slot bit one cycle ahead. Its prediction is compared with the outputs at every falling edge, half a cycle after the registers update. Stimulus changes only just after falling edges, and words change on the non-capturing pixel edge. A word is therefore steady for at least three bit cycles around its load.

// File: rtl/px7_pkg.sv
package px7_pkg;

  // Word bit that feeds a given lane and slot (fixed scrambled map).
  function automatic int unsigned src_bit(input int unsigned lane, input int unsigned slot);
    int unsigned idx;
    idx = lane * 7 + slot;
    case (idx)
      0: return 1;   1: return 0;   2: return 7;   3: return 6;
      4: return 4;   5: return 3;   6: return 2;
      7: return 9;   8: return 8;   9: return 18;  10: return 15;
      11: return 14; 12: return 13; 13: return 12;
      14: return 20; 15: return 19; 16: return 26; 17: return 25;
      18: return 24; 19: return 22; 20: return 21;
      21: return 5;  22: return 27; 23: return 23; 24: return 17;
      25: return 16; 26: return 11; 27: return 10;
      default: return 0;
    endcase
  endfunction

  // Framing clock level for a slot index.
  function automatic logic frame_level(input int unsigned slot, input int unsigned high_slots);
    return slot < high_slots;
  endfunction

endpackage

// File: rtl/px7_edge_sync.sv
module px7_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic run_en,
  input  logic pix_clk,
  input  logic rise_sel,
  output logic load_stb
);
  logic [STAGES:0] chain;
  logic new_lvl, old_lvl;

  always_ff @(posedge clk or negedge run_en) begin
    if (!run_en) chain <= '0;
    else         chain <= {chain[STAGES-1:0], pix_clk};
  end

  assign new_lvl  = chain[STAGES-1];
  assign old_lvl  = chain[STAGES];
  assign load_stb = (new_lvl != old_lvl) && (new_lvl == rise_sel);

  // R7: one pixel-clock edge yields a single-cycle strobe
  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!run_en)
    load_stb |=> !load_stb);

endmodule

// File: rtl/px7_slot_map.sv
module px7_slot_map #(
  parameter int LANES = 4,
  parameter int SLOTS = 7
) (
  input  logic [LANES*SLOTS-1:0]        word,
  output logic [LANES-1:0][SLOTS-1:0]   slices
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slices[l][s] = word[px7_pkg::src_bit(l, s)];
    end
  end
endmodule

// File: rtl/px7_lane_shift.sv
module px7_lane_shift #(
  parameter int LANES     = 4,
  parameter int SLOTS     = 7,
  parameter int CLK_HIGH  = 4,
  localparam int PH_W     = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          run_en,
  input  logic                          load_stb,
  input  logic [LANES-1:0][SLOTS-1:0]   slices,
  output logic [LANES-1:0]              lane_out,
  output logic                          clk_out,
  output logic                          locked
);
  logic [LANES-1:0][SLOTS-1:0] hold, src;
  logic [PH_W-1:0]             phase, sel_ph, next_ph;
  logic [LANES-1:0]            bits;
  logic                        active;

  always_comb begin
    sel_ph  = load_stb ? '0 : phase;
    src     = load_stb ? slices : hold;
    active  = load_stb | locked;
    next_ph = (sel_ph == PH_W'(SLOTS - 1)) ? '0 : sel_ph + PH_W'(1);
    for (int l = 0; l < LANES; l++) bits[l] = src[l][sel_ph];
  end

  always_ff @(posedge clk or negedge run_en) begin
    if (!run_en) begin
      hold     <= '0;
      phase    <= '0;
      lane_out <= '0;
      clk_out  <= 1'b0;
      locked   <= 1'b0;
    end else begin
      hold     <= src;
      phase    <= next_ph;
      lane_out <= active ? bits : '0;
      clk_out  <= active && px7_pkg::frame_level(int'(sel_ph), CLK_HIGH);
      locked   <= active;
    end
  end

  // R5: shutdown keeps all outputs quiet
  assert_quiet_off_R5: assert property (@(posedge clk)
    !run_en |-> (lane_out == '0 && !clk_out && !locked));

  // R6: nothing leaves before the first load
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!run_en)
    !locked |-> (lane_out == '0 && !clk_out));

  // R7: a load drives slot 0 with the framing clock high on the next edge
  assert_load_slot0_R7: assert property (@(posedge clk) disable iff (!run_en)
    load_stb |=> (clk_out && locked));

  // R2: framing clock high phase spans four bit cycles
  assert_clk_width_R2: assert property (@(posedge clk) disable iff (!run_en)
    $fell(clk_out) |-> ($past(clk_out, 4) && !$past(clk_out, 5)));

endmodule

// File: rtl/px7_serializer.sv
module px7_serializer #(
  parameter int LANES       = 4,
  parameter int SLOTS       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_HIGH    = 4,
  localparam int WORD_W     = LANES * SLOTS
) (
  input  logic              clk,
  input  logic              run_en,
  input  logic              pix_clk,
  input  logic              rise_sel,
  input  logic [WORD_W-1:0] pix_word,
  output logic [LANES-1:0]  lane_out,
  output logic              clk_out,
  output logic              locked
);
  logic                        load_stb;
  logic [LANES-1:0][SLOTS-1:0] slices;

  px7_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .run_en(run_en), .pix_clk(pix_clk), .rise_sel(rise_sel), .load_stb(load_stb)
  );

  px7_slot_map #(.LANES(LANES), .SLOTS(SLOTS)) u_map (
    .word(pix_word), .slices(slices)
  );

  px7_lane_shift #(.LANES(LANES), .SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) u_shift (
    .clk(clk), .run_en(run_en), .load_stb(load_stb), .slices(slices),
    .lane_out(lane_out), .clk_out(clk_out), .locked(locked)
  );
endmodule

// File: tb/px7_serializer_tb.sv
module px7_serializer_tb;
  logic        clk = 0, run_en = 0, pix_clk = 0, rise_sel = 1;
  logic [27:0] pix_word = '0;
  wire  [3:0]  lane_out;
  wire         clk_out, locked;

  px7_serializer u_dut (
    .clk(clk), .run_en(run_en), .pix_clk(pix_clk), .rise_sel(rise_sel),
    .pix_word(pix_word), .lane_out(lane_out), .clk_out(clk_out), .locked(locked)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit started = 0, finished = 0, chk18 = 0;
  int src_tab[28] = '{1,0,7,6,4,3,2, 9,8,18,15,14,13,12,
                      20,19,26,25,24,22,21, 5,27,23,17,16,11,10};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_slot(input logic [27:0] w, input int s);
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = w[src_tab[l*7 + s]];
    return r;
  endfunction

  // Behavioural reference: predicts what the outputs hold after each rising edge.
  bit          q[$] = '{0, 0, 0};
  int          m_ph = 0;
  bit          m_lock = 0;
  logic [27:0] m_word = '0;
  logic [3:0]  e_lane = '0;
  bit          e_clk = 0, e_lock = 0;

  always @(posedge clk) begin
    started = 1;
    if (!run_en) begin
      q = '{0, 0, 0}; m_ph = 0; m_lock = 0; m_word = '0;
      e_lane = '0; e_clk = 0; e_lock = 0;
    end else begin
      bit stb;
      int sel;
      stb = (q[$-1] != q[$-2]) && (q[$-1] == rise_sel);
      if (stb) m_word = pix_word;
      sel    = stb ? 0 : m_ph;
      e_lane = (stb || m_lock) ? exp_slot(m_word, sel) : 4'h0;
      e_clk  = (stb || m_lock) && (sel < 4);
      m_lock = m_lock || stb;
      e_lock = m_lock;
      m_ph   = (sel + 1) % 7;
      q.push_back(pix_clk);
      void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(lane_out === e_lane, "R1 lanes", int'(lane_out), int'(e_lane));
      chk(clk_out === e_clk, "R2 clk_out", int'(clk_out), int'(e_clk));
      chk(locked === e_lock, "R6 locked", int'(locked), int'(e_lock));
      if (chk18) chk(lane_out[3] === 1'b0, "R8 lane3", int'(lane_out[3]), 0);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic pixel(input logic [27:0] w);
    for (int i = 0; i < 7; i++) begin
      tick();
      if (i == 0) begin pix_clk = ~rise_sel; pix_word = w; end
      if (i == 3) pix_clk = rise_sel;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [27:0] wa, wc, wl;
    logic [3:0]  seen[14];
    wa = 28'hA5C3E17; wc = 28'h5B1D2C8; wl = 28'h9D36A5B;
    repeat (3) tick();
    chk(lane_out == 0 && !clk_out && !locked, "R5 reset", {lane_out, clk_out, locked}, 0);
    run_en = 1;
    repeat (6) begin
      tick();
      chk(lane_out == 0 && !clk_out && !locked, "R6 idle", {lane_out, clk_out, locked}, 0);
    end
    // R3/R7: rising capture, slot 0 on the third falling edge after the stimulus
    pix_word = wa;
    repeat (3) tick();
    tick(); pix_clk = 1;
    tick(); chk(!clk_out, "R7 early", clk_out, 0);
    tick(); chk(!clk_out && !locked, "R3 early", {clk_out, locked}, 0);
    tick(); chk(clk_out && locked && lane_out == exp_slot(wa, 0), "R3 slot0",
                {lane_out, clk_out, locked}, {exp_slot(wa, 0), 2'b11});
    for (int k = 0; k < 28; k++) pixel(28'h1 << k);
    for (int k = 0; k < 8; k++) pixel(28'($urandom));
    pixel(wl);
    // R9: pixel clock halted, last word repeats
    for (int i = 0; i < 14; i++) begin tick(); seen[i] = lane_out; end
    for (int i = 0; i < 7; i++) begin
      chk(seen[i] == exp_slot(wl, (i + 1) % 7), "R9 repeat", seen[i], exp_slot(wl, (i + 1) % 7));
      chk(seen[i + 7] == seen[i], "R9 second", seen[i + 7], seen[i]);
    end
    // R8: reduced-colour words
    for (int k = 0; k < 10; k++) begin
      pixel(28'($urandom) & ~28'h8830C20);
      if (k == 1) chk18 = 1;
    end
    chk18 = 0;
    // R5: asynchronous shutdown
    tick(); run_en = 0; #1;
    chk(lane_out == 0 && !clk_out && !locked, "R5 async", {lane_out, clk_out, locked}, 0);
    repeat (4) begin
      tick();
      chk(lane_out == 0 && !clk_out && !locked, "R5 hold", {lane_out, clk_out, locked}, 0);
    end
    rise_sel = 0; pix_clk = 0;
    tick(); run_en = 1;
    // R4: rising edge ignored, falling edge captures
    tick(); pix_clk = 1; pix_word = wc;
    repeat (4) begin tick(); chk(!locked && !clk_out, "R4 ignore", {clk_out, locked}, 0); end
    pix_clk = 0;
    tick(); chk(!clk_out, "R4 early", clk_out, 0);
    tick(); chk(!clk_out && !locked, "R4 early", {clk_out, locked}, 0);
    tick(); chk(clk_out && locked && lane_out == exp_slot(wc, 0), "R4 slot0",
                {lane_out, clk_out, locked}, {exp_slot(wc, 0), 2'b11});
    for (int k = 0; k < 10; k++) pixel(28'($urandom));
    repeat (3) tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule